// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A baud generator elsewhere supplies a single-cycle oversampling enable, `tick`, at 16 times the bit rate. The receiver waits in idle for the line to fall. It confirms the start bit at its centre and then reads each following bit near its centre. Each bit value is a two-out-of-three vote over three consecutive ticks.

Framing is set by configuration inputs: 5 to 9 data bits, even, odd or no parity, and one or two stop bits. Each finished character is written to a downstream receive buffer with a one-cycle strobe. The strobe carries the data and three error flags: parity, framing and break. If the buffer reports full when a character completes, the character is dropped and a one-cycle overrun pulse is raised instead. The buffer storage itself is not part of this block.

Top module: `serial_rx_unit`

## Requirements
- R1: A character is started only by a falling edge of `rxd` while idle. The line must have been seen high in idle after the previous character before a low level can start a new one, so a line held low after a break produces exactly one character.
- R2: Each bit value is the majority of three samples taken at ticks 7, 8 and 9 of the bit's 16-tick period. A low or high pulse of one clock that hits only one of the three samples does not change the received value.
- R3: If the vote at the centre of the start bit is 1, the start is false. The receiver returns to idle and writes nothing.
- R4: `cfg_len` codes 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits; codes 5 to 7 select 9. Data arrives LSB first and is presented right-aligned in `wr_data`, with the unused upper bits 0.
- R5: If `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd` = 0 the total count of ones over the data and parity bits must be even; with `cfg_par_odd` = 1 it must be odd. A mismatch sets `wr_err[0]`.
- R6: If the vote at the first stop bit is 0, `wr_err[1]` (framing) is set.
- R7: If every data bit, the parity bit (when enabled) and the first stop bit all vote 0, `wr_err[2]` (break) is set together with `wr_err[1]`, and `wr_data` is 0.
- R8: `wr_en` is high for exactly one cycle per character. With `tick` high every cycle, it is high in the cycle that begins 13 + 16·s clocks after `rxd` first goes low. Here s = 1 + data bits + parity bits is the index of the first stop bit.
- R9: If `buf_full` is high on the cycle a character completes, `wr_en` stays low and `overrun` is high for one cycle at the time `wr_en` would have been.
- R10: With `cfg_two_stop` = 1, the receiver stays busy through the second stop bit and does not check it, so a low level during that bit time starts no character.
- R11: While `rst` is high and in the cycle after it falls, `wr_en` and `overrun` are 0.
- R12: The bit timing advances only on cycles with `tick` high, so a slower tick rate stretches each bit and reception stays correct. `wr_en` and `overrun` rise only on an edge where `tick` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 3 | Data-length code (0..4 = 5..9 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| buf_full | input | 1 | Receive buffer cannot accept a write |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 9 | Received character, right-aligned |
| wr_err | output | 3 | {break, framing, parity} flags for the character |
| overrun | output | 1 | One-cycle pulse: character dropped, buffer full |

## Verification
The strobe and the overrun pulse are registered on the edge that evaluates the vote at the first stop bit. When `tick` is high every cycle, the falling start edge passes through two synchronizer stages and one idle-to-start transition, so either pulse becomes visible 13 + 16·s clock edges after the launch. The bench records the clock count at launch and at each strobe, sampling on the falling clock edge, and compares the difference with that figure for every table vector and for the overrun case. Tests with a slower tick rate, and tests where no character is expected, check the strobe counts and captured values only after an idle gap longer than a full frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int DATA_MAX = 9;
    localparam int OSR      = 16;
    localparam int CNT_W    = $clog2(OSR);
    localparam int LEN_W    = $clog2(DATA_MAX + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_t;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_err_t;

    function automatic logic [LEN_W-1:0] data_bits(input logic [2:0] code);
        if (code > 3'd4) return LEN_W'(DATA_MAX);
        return LEN_W'(code) + LEN_W'(5);
    endfunction

    function automatic logic [DATA_MAX-1:0] align_right(input logic [DATA_MAX-1:0] sh,
                                                        input logic [LEN_W-1:0] n);
        return sh >> (LEN_W'(DATA_MAX) - n);
    endfunction

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_bitclk.sv
module serial_rx_bitclk
    import serial_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    input  logic rx,
    output logic mid,
    output logic vote
);
    localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OSR / 2 + 1);
    localparam logic [CNT_W-1:0] V0_CNT  = MID_CNT - CNT_W'(2);
    localparam logic [CNT_W-1:0] V1_CNT  = MID_CNT - CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP_CNT = CNT_W'(OSR - 1);

    logic [CNT_W-1:0] cnt;
    logic             s0, s1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == TOP_CNT) ? '0 : cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s0 <= 1'b1;
            s1 <= 1'b1;
        end else if (run && tick) begin
            if (cnt == V0_CNT) s0 <= rx;
            if (cnt == V1_CNT) s1 <= rx;
        end
    end

    assign mid  = run && tick && (cnt == MID_CNT);
    assign vote = vote3(s0, s1, rx);
endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
    import serial_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rx,
    input  logic                mid,
    input  logic                vote,
    input  logic [2:0]          cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    input  logic                buf_full,
    output logic                run,
    output logic                wr_en,
    output logic [DATA_MAX-1:0] wr_data,
    output rx_err_t             wr_err,
    output logic                overrun
);
    rx_state_t           state;
    logic                armed;
    logic [DATA_MAX-1:0] sh;
    logic [LEN_W-1:0]    bidx;
    logic                par_acc;
    logic                par_bad;
    logic                all_zero;
    logic [LEN_W-1:0]    nbits;

    assign nbits = data_bits(cfg_len);
    assign run   = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            armed    <= 1'b0;
            sh       <= '0;
            bidx     <= '0;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
            all_zero <= 1'b1;
            wr_en    <= 1'b0;
            overrun  <= 1'b0;
            wr_data  <= '0;
            wr_err   <= '0;
        end else begin
            wr_en   <= 1'b0;
            overrun <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (rx) armed <= 1'b1;
                    if (armed && !rx) state <= ST_START;
                end
                ST_START: if (mid) begin
                    if (vote) begin
                        state <= ST_IDLE;
                        armed <= 1'b0;
                    end else begin
                        state    <= ST_DATA;
                        bidx     <= '0;
                        sh       <= '0;
                        par_acc  <= 1'b0;
                        par_bad  <= 1'b0;
                        all_zero <= 1'b1;
                    end
                end
                ST_DATA: if (mid) begin
                    sh       <= {vote, sh[DATA_MAX-1:1]};
                    par_acc  <= par_acc ^ vote;
                    all_zero <= all_zero & ~vote;
                    bidx     <= bidx + LEN_W'(1);
                    if (bidx == nbits - LEN_W'(1))
                        state <= cfg_par_en ? ST_PAR : ST_STOP;
                end
                ST_PAR: if (mid) begin
                    par_bad  <= par_acc ^ vote ^ cfg_par_odd;
                    all_zero <= all_zero & ~vote;
                    state    <= ST_STOP;
                end
                ST_STOP: if (mid) begin
                    wr_data    <= align_right(sh, nbits);
                    wr_err.par <= par_bad;
                    wr_err.frm <= ~vote;
                    wr_err.brk <= all_zero & ~vote;
                    if (buf_full) overrun <= 1'b1;
                    else          wr_en   <= 1'b1;
                    armed <= 1'b0;
                    state <= cfg_two_stop ? ST_STOP2 : ST_IDLE;
                end
                ST_STOP2: if (mid) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                rxd,
    input  logic [2:0]          cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    input  logic                buf_full,
    output logic                wr_en,
    output logic [DATA_MAX-1:0] wr_data,
    output logic [2:0]          wr_err,
    output logic                overrun
);
    logic    rx_s;
    logic    run;
    logic    mid;
    logic    vote;
    rx_err_t err_s;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_s)
    );

    serial_rx_bitclk u_bitclk (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .run  (run),
        .rx   (rx_s),
        .mid  (mid),
        .vote (vote)
    );

    serial_rx_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .rx           (rx_s),
        .mid          (mid),
        .vote         (vote),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .buf_full     (buf_full),
        .run          (run),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wr_err       (err_s),
        .overrun      (overrun)
    );

    assign wr_err = err_s;
endmodule

// File: rtl/serial_rx_unit_chk.sv
module serial_rx_unit_chk
    import serial_rx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic                buf_full,
    input logic                wr_en,
    input logic [DATA_MAX-1:0] wr_data,
    input logic [2:0]          wr_err,
    input logic                overrun
);
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    assert_overrun_single_R9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> !overrun);

    assert_wr_or_ovr_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && overrun));

    assert_ovr_needs_full_R9: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(buf_full));

    assert_wr_needs_room_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(buf_full));

    assert_break_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_err[2]) |-> (wr_err[1] && wr_data == '0));

    assert_pulse_on_tick_R12: assert property (@(posedge clk) disable iff (rst)
        ($rose(wr_en) || $rose(overrun)) |-> $past(tick));
endmodule

bind serial_rx_unit serial_rx_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .buf_full (buf_full),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_err   (wr_err),
    .overrun  (overrun)
);

// File: tb/serial_rx_unit_test.sv
module serial_rx_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       rxd = 1'b1;
    logic [2:0] cfg_len = 3'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       buf_full = 1'b0;
    logic       wr_en;
    logic [8:0] wr_data;
    logic [2:0] wr_err;
    logic       overrun;

    serial_rx_unit uut (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .buf_full(buf_full),
        .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {len, par_en, par_odd, flip_par, stop, data[8:0], exp_err{brk,frm,par}}
    localparam logic [18:0] VEC [NVEC] = '{
        {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0A5, 3'b000},
        {3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h1F5, 3'b000},
        {3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 9'h04B, 3'b000},
        {3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 9'h03C, 3'b000},
        {3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 9'h1A7, 3'b000},
        {3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 9'h055, 3'b001},
        {3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h02A, 3'b010},
        {3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 3'b110},
        {3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, 3'b111}
    };

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int tick_div = 1;
    int tick_ph = 0;
    int n_strobe = 0;
    int n_ovr = 0;
    int cap_cyc = 0;
    int ovr_cyc = 0;
    int launch_cyc = 0;
    logic [8:0] cap_data = '0;
    logic [2:0] cap_err = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tick_ph + 1 >= tick_div) begin
            tick_ph = 0;
            tick <= 1'b1;
        end else begin
            tick_ph = tick_ph + 1;
            tick <= 1'b0;
        end
        if (wr_en) begin
            n_strobe = n_strobe + 1;
            cap_data = wr_data;
            cap_err  = wr_err;
            cap_cyc  = cyc;
        end
        if (overrun) begin
            n_ovr   = n_ovr + 1;
            ovr_cyc = cyc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [2:0] code);
        return (code > 3'd4) ? 9 : int'(code) + 5;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drives start, data (LSB first), optional parity and first stop bit.
    // Leaves rxd at the stop value.
    task automatic send_frame(input logic [2:0] len, input logic pe, input logic po,
                              input logic flip, input logic stopv, input logic [8:0] data,
                              input int bitlen, input int gbit);
        logic line [12];
        int   nb;
        int   cnt;
        logic p;
        nb = nbits_of(len);
        line[0] = 1'b0;
        p = 1'b0;
        for (int i = 0; i < nb; i++) begin
            line[1+i] = data[i];
            p = p ^ data[i];
        end
        cnt = 1 + nb;
        if (pe) begin
            line[cnt] = p ^ po ^ flip;
            cnt++;
        end
        line[cnt] = stopv;
        cnt++;
        @(negedge clk);
        for (int b = 0; b < cnt; b++) begin
            for (int c = 0; c < bitlen; c++) begin
                rxd = (b == gbit && c == 9) ? ~line[b] : line[b];
                if (b == 0 && c == 0) launch_cyc = cyc;
                @(negedge clk);
            end
        end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int s0;
        int o0;
        int nb;
        int s;
        logic [8:0] mask;
        idle(4);
        chk("R11 wr_en in reset", int'(wr_en), 0);
        chk("R11 overrun in reset", int'(overrun), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 wr_en after reset", int'(wr_en), 0);
        chk("R11 overrun after reset", int'(overrun), 0);
        idle(10);

        // Table walk: R4 lengths, R5 parity, R6 framing, R7 break, R8 latency
        for (int k = 0; k < NVEC; k++) begin
            cfg_len     = VEC[k][18:16];
            cfg_par_en  = VEC[k][15];
            cfg_par_odd = VEC[k][14];
            s0 = n_strobe;
            send_frame(VEC[k][18:16], VEC[k][15], VEC[k][14], VEC[k][13], VEC[k][12],
                       VEC[k][11:3], 16, -1);
            rxd = 1'b1;
            idle(60);
            nb = nbits_of(VEC[k][18:16]);
            mask = 9'((1 << nb) - 1);
            s = 1 + nb + int'(VEC[k][15]);
            chk($sformatf("R8 strobe count vec %0d", k), n_strobe - s0, 1);
            chk($sformatf("R4 data vec %0d", k), int'(cap_data), int'(VEC[k][11:3] & mask));
            chk($sformatf("R5/R6/R7 err vec %0d", k), int'(cap_err), int'(VEC[k][2:0]));
            chk($sformatf("R8 latency vec %0d", k), cap_cyc - launch_cyc, 13 + 16 * s);
        end

        // R3 false start: short low pulse
        cfg_len = 3'd3; cfg_par_en = 1'b0;
        s0 = n_strobe;
        rxd = 1'b0; idle(5); rxd = 1'b1; idle(300);
        chk("R3 false start no strobe", n_strobe - s0, 0);
        send_frame(3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0C3, 16, -1);
        idle(60);
        chk("R3 receiver rearmed after false start", int'(cap_data), 'hC3);

        // R2 majority: one-clock glitch at a sample point
        s0 = n_strobe;
        send_frame(3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0FF, 16, 4);
        idle(60);
        chk("R2 glitch strobe count", n_strobe - s0, 1);
        chk("R2 glitch data", int'(cap_data), 'hFF);
        chk("R2 glitch err", int'(cap_err), 0);
        send_frame(3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 9'h000, 16, 3);
        idle(60);
        chk("R2 high glitch data", int'(cap_data), 0);

        // R9 overrun
        buf_full = 1'b1;
        s0 = n_strobe; o0 = n_ovr;
        send_frame(3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 9'h033, 16, -1);
        idle(60);
        chk("R9 no write when full", n_strobe - s0, 0);
        chk("R9 overrun pulse", n_ovr - o0, 1);
        chk("R9 overrun latency", ovr_cyc - launch_cyc, 13 + 16 * 9);
        buf_full = 1'b0;

        // R1 break held low: single character, rearm only after high
        s0 = n_strobe;
        send_frame(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 16, -1);
        idle(80);
        chk("R1 held-low break gives one char", n_strobe - s0, 1);
        chk("R7 break err", int'(cap_err), 6);
        rxd = 1'b1; idle(60);
        chk("R1 no char on release", n_strobe - s0, 1);
        send_frame(3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 9'h05A, 16, -1);
        idle(60);
        chk("R1 rearmed after break", int'(cap_data), 'h5A);

        // R10 two stop bits: low during the second stop bit is ignored
        cfg_two_stop = 1'b1;
        s0 = n_strobe;
        send_frame(3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 9'h081, 16, -1);
        rxd = 1'b0; idle(16); rxd = 1'b1; idle(300);
        chk("R10 one char only", n_strobe - s0, 1);
        chk("R10 data", int'(cap_data), 'h81);
        cfg_two_stop = 1'b0;

        // R12 slow tick
        tick_div = 3;
        cfg_len = 3'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        idle(10);
        s0 = n_strobe;
        send_frame(3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 9'h05A, 48, -1);
        idle(200);
        chk("R12 slow tick strobe", n_strobe - s0, 1);
        chk("R12 slow tick data", int'(cap_data), 'h5A);
        chk("R12 slow tick err", int'(cap_err), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule